// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is one DMA channel. It copies a run of equal-width elements between a device location that does not move and a memory location that advances after every element. A transfer is described by four 32-bit words: device address, memory address, size and link. The surrounding register logic presents these words on the load inputs and pulses `start`. The engine then moves the data through a simple request/acknowledge memory master port.

In scatter-gather mode, a completed descriptor whose link code says "follow" makes the engine read the next four-word descriptor from memory. It then carries on with that descriptor. In single-shot mode it stops after the loaded descriptor, whatever the link code says. The 2-bit state output tells software whether the channel is idle, reading a descriptor, waiting or moving data. One-cycle `irq` and `err` pulses report completion and bad descriptors.

Top module: `dmac_chain_engine`

## Requirements
- R1: While reset is held (synchronous, active low), `state` is 0, `mem_req` is low and `irq` and `err` are low.
- R2: Size word bits [13:12] select the element width: 3 is 1 byte, 2 is 2 bytes, 0 is 4 bytes. The memory address advances by the element width after each element. The device address never changes within a descriptor.
- R3: Size word bits [11:0] give the element count. Each element is one read followed by one write. A count of 0 completes the descriptor with no memory access.
- R4: A descriptor is rejected when its width code is 1, when its count exceeds 0x3FF for the 1-byte or 2-byte width, or when its count exceeds 0x7FF for the 4-byte width. On a rejected descriptor, `irq` and `err` pulse together, no element is moved and the engine returns to idle. A count equal to the limit is accepted.
- R5: Link word bits [1:0] give the end code: 0 = end, no interrupt; 1 = end with interrupt; 2 = follow, no interrupt; 3 = follow with interrupt. Bit 0 set gives one `irq` pulse when that descriptor completes.
- R6: In scatter-gather mode (`mode` = 1), a completed descriptor with link bit 1 set starts a fetch. The engine makes four 4-byte reads at {link[31:2],2'b00} plus 0, 4, 8 and 12. These read the device address, memory address, size and link, in that order. `state` is 1 during the fetch. The fetched descriptor then runs.
- R7: In single-shot mode (`mode` = 2 or 3), the engine runs only the loaded descriptor and then goes idle, even when its link code is 2 or 3.
- R8: With `dir` = 0, each element is read from the device address and written to the memory address. With `dir` = 1, each element is read from the memory address and written to the device address. The written data equals the data read.
- R9: `state` encodes 0 idle, 1 descriptor read, 2 wait, 3 access. A start accepted at a clock edge gives `state` = 2 after that edge. A valid non-empty descriptor gives `state` = 3 one edge later.
- R10: Setting `mode` to 0 while busy stops the engine. It returns to idle at the edge that completes the current element's write, with no `irq` and no `err`.
- R11: A `start` pulse while `mode` is 0 is ignored. The engine stays idle and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that loads the descriptor words and starts the channel |
| mode | input | 2 | 0 disabled, 1 scatter-gather, 2 or 3 single-shot |
| dir | input | 1 | 0 device to memory, 1 memory to device |
| ld_dev | input | AW | Device address of the loaded descriptor |
| ld_mem | input | AW | Memory address of the loaded descriptor |
| ld_size | input | 32 | Size word of the loaded descriptor |
| ld_next | input | 32 | Link word of the loaded descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_width | output | 2 | Access width, using the size-word width code |
| mem_ack | input | 1 | Access done this cycle; read data is valid with it |
| mem_rdata | input | DW | Read data |
| state | output | 2 | Channel state |
| irq | output | 1 | One-cycle completion or error interrupt pulse |
| err | output | 1 | One-cycle bad-descriptor pulse |

## Verification
An accepted start shows `state` = 2 one edge later and `state` = 3 the edge after that. With an always-ready memory, each element takes two cycles and each fetched descriptor takes four. `irq` and `err` are registered, so they rise on the same edge at which `state` returns to idle, or at which it enters the fetch. The bench samples every output at the falling edge. After it sees idle, it waits two more falling edges and only then compares its pulse and access counters. This ensures no pulse or final write is missed or sampled early.

// File: rtl/dmac_pkg.sv
// Shared encodings for the DMA channel engine.
// Assumes descriptor words are 32 bits wide.
package dmac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_XFER  = 2'd3
    } chan_state_e;

    localparam logic [1:0] MODE_OFF = 2'd0;
    localparam logic [1:0] MODE_SG  = 2'd1;

    localparam logic [1:0] WID_1B = 2'd3;
    localparam logic [1:0] WID_2B = 2'd2;
    localparam logic [1:0] WID_4B = 2'd0;

    localparam int DESC_W  = 32;
    localparam int SIZE_KEEP = 14;  // count [11:0] plus width [13:12]
endpackage

// File: rtl/dmac_desc_check.sv
// Decodes the size word of the active descriptor.
// Gives the element step in bytes and whether width and count are legal.
// Purely combinational; assumes the count sits in the low CNT_W bits.
module dmac_desc_check
    import dmac_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int LIM_NARROW = 1023,
    parameter int LIM_WIDE   = 2047
) (
    input  logic [SIZE_KEEP-1:0] size_word,
    output logic                 valid,
    output logic [2:0]           step_bytes
);
    logic [CNT_W-1:0] cnt;
    logic [1:0]       wcode;

    assign cnt   = size_word[CNT_W-1:0];
    assign wcode = size_word[13:12];

    // Width decode and count limit per width
    always_comb begin
        unique case (wcode)
            WID_1B: begin
                step_bytes = 3'd1;
                valid      = (cnt <= CNT_W'(LIM_NARROW));
            end
            WID_2B: begin
                step_bytes = 3'd2;
                valid      = (cnt <= CNT_W'(LIM_NARROW));
            end
            WID_4B: begin
                step_bytes = 3'd4;
                valid      = (cnt <= CNT_W'(LIM_WIDE));
            end
            default: begin
                step_bytes = 3'd0;
                valid      = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dmac_desc_regs.sv
// Live copy of the active descriptor and the remaining element count.
// Loaded as a whole on start, or one word at a time during a fetch.
// Assumes AW <= 32; fetched words arrive in order dev, mem, size, link.
module dmac_desc_regs
    import dmac_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_all,
    input  logic [AW-1:0]        ld_dev,
    input  logic [AW-1:0]        ld_mem,
    input  logic [DESC_W-1:0]    ld_size,
    input  logic [DESC_W-1:0]    ld_next,
    input  logic                 fetch_we,
    input  logic [1:0]           fetch_idx,
    input  logic [DESC_W-1:0]    fetch_word,
    input  logic                 step_en,
    input  logic [2:0]           step_bytes,
    output logic [AW-1:0]        dev_q,
    output logic [AW-1:0]        mem_q,
    output logic [SIZE_KEEP-1:0] size_q,
    output logic [DESC_W-1:0]    next_q,
    output logic [CNT_W-1:0]     rem_q
);
    logic unused_size_hi;
    assign unused_size_hi = ^{ld_size[DESC_W-1:SIZE_KEEP], fetch_word[DESC_W-1:SIZE_KEEP]};

    // Descriptor word storage with per-element advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q  <= '0;
            mem_q  <= '0;
            size_q <= '0;
            next_q <= '0;
            rem_q  <= '0;
        end else if (load_all) begin
            dev_q  <= ld_dev;
            mem_q  <= ld_mem;
            size_q <= ld_size[SIZE_KEEP-1:0];
            rem_q  <= ld_size[CNT_W-1:0];
            next_q <= ld_next;
        end else if (fetch_we) begin
            unique case (fetch_idx)
                2'd0: dev_q <= AW'(fetch_word);
                2'd1: mem_q <= AW'(fetch_word);
                2'd2: begin
                    size_q <= fetch_word[SIZE_KEEP-1:0];
                    rem_q  <= fetch_word[CNT_W-1:0];
                end
                default: next_q <= fetch_word;
            endcase
        end else if (step_en) begin
            mem_q <= mem_q + AW'(step_bytes);
            rem_q <= rem_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/dmac_chain_engine.sv
// Single DMA channel that walks a chain of four-word descriptors.
// Each element is a read, then a write, through a request/acknowledge port.
// Assumes mem_ack completes the request in the cycle it is high, and DW >= 32.
module dmac_chain_engine
    import dmac_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic              dir,
    input  logic [AW-1:0]     ld_dev,
    input  logic [AW-1:0]     ld_mem,
    input  logic [31:0]       ld_size,
    input  logic [31:0]       ld_next,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic [1:0]        mem_width,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic [1:0]        state,
    output logic              irq,
    output logic              err
);
    chan_state_e st_q, st_d;
    logic        wr_phase_q, wr_phase_d;
    logic [1:0]  idx_q, idx_d;
    logic [DW-1:0] data_q;
    logic [AW-1:0] link_q;
    logic        irq_q, err_q, irq_d, err_d;
    logic        load_all, fetch_we, step_en, finish, link_upd;

    logic [AW-1:0]        dev_q, mem_q;
    logic [SIZE_KEEP-1:0] size_q;
    logic [31:0]          next_q;
    logic [CNT_W-1:0]     rem_q;
    logic                 desc_ok;
    logic [2:0]           step_bytes;
    logic                 chain_go;

    dmac_desc_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_all   (load_all),
        .ld_dev     (ld_dev),
        .ld_mem     (ld_mem),
        .ld_size    (ld_size),
        .ld_next    (ld_next),
        .fetch_we   (fetch_we),
        .fetch_idx  (idx_q),
        .fetch_word (mem_rdata[31:0]),
        .step_en    (step_en),
        .step_bytes (step_bytes),
        .dev_q      (dev_q),
        .mem_q      (mem_q),
        .size_q     (size_q),
        .next_q     (next_q),
        .rem_q      (rem_q)
    );

    dmac_desc_check #(.CNT_W(CNT_W)) u_check (
        .size_word  (size_q),
        .valid      (desc_ok),
        .step_bytes (step_bytes)
    );

    assign chain_go = next_q[1] && (mode == MODE_SG);

    // Next-state and control decode for the channel sequencer
    always_comb begin
        st_d       = st_q;
        wr_phase_d = wr_phase_q;
        idx_d      = idx_q;
        irq_d      = 1'b0;
        err_d      = 1'b0;
        load_all   = 1'b0;
        fetch_we   = 1'b0;
        step_en    = 1'b0;
        finish     = 1'b0;
        link_upd   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start && mode != MODE_OFF) begin
                    load_all = 1'b1;
                    st_d     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mode == MODE_OFF) begin
                    st_d = ST_IDLE;
                end else if (!desc_ok) begin
                    st_d  = ST_IDLE;
                    irq_d = 1'b1;
                    err_d = 1'b1;
                end else if (rem_q == '0) begin
                    finish = 1'b1;
                end else begin
                    st_d       = ST_XFER;
                    wr_phase_d = 1'b0;
                end
            end
            ST_XFER: begin
                if (mem_ack) begin
                    if (!wr_phase_q) begin
                        wr_phase_d = 1'b1;
                    end else begin
                        step_en = 1'b1;
                        if (mode == MODE_OFF) begin
                            st_d = ST_IDLE;
                        end else if (rem_q == CNT_W'(1)) begin
                            finish = 1'b1;
                        end else begin
                            wr_phase_d = 1'b0;
                        end
                    end
                end
            end
            default: begin
                if (mem_ack) begin
                    fetch_we = 1'b1;
                    if (idx_q == 2'd3) begin
                        st_d = ST_WAIT;
                    end else begin
                        idx_d = idx_q + 2'd1;
                    end
                end
            end
        endcase
        if (finish) begin
            irq_d = next_q[0];
            if (chain_go) begin
                st_d     = ST_FETCH;
                idx_d    = 2'd0;
                link_upd = 1'b1;
            end else begin
                st_d = ST_IDLE;
            end
        end
    end

    // Sequencer state, pulses and fetch pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            wr_phase_q <= 1'b0;
            idx_q      <= 2'd0;
            irq_q      <= 1'b0;
            err_q      <= 1'b0;
            link_q     <= '0;
        end else begin
            st_q       <= st_d;
            wr_phase_q <= wr_phase_d;
            idx_q      <= idx_d;
            irq_q      <= irq_d;
            err_q      <= err_d;
            if (link_upd) begin
                link_q <= AW'({next_q[31:2], 2'b00});
            end
        end
    end

    // Element data holding register between read and write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (st_q == ST_XFER && !wr_phase_q && mem_ack) begin
            data_q <= mem_rdata;
        end
    end

    // Memory port drive: fetch reads or element read/write
    always_comb begin
        mem_req   = (st_q == ST_XFER) || (st_q == ST_FETCH);
        mem_we    = (st_q == ST_XFER) && wr_phase_q;
        mem_wdata = data_q;
        if (st_q == ST_FETCH) begin
            mem_addr  = link_q + AW'({idx_q, 2'b00});
            mem_width = WID_4B;
        end else begin
            mem_addr  = (wr_phase_q == dir) ? dev_q : mem_q;
            mem_width = size_q[13:12];
        end
    end

    assign state = st_q;
    assign irq   = irq_q;
    assign err   = err_q;
endmodule

// File: rtl/dmac_chain_engine_chk.sv
// Protocol checker for the DMA channel engine, attached by bind.
module dmac_chain_engine_chk
    import dmac_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [1:0] mode,
    input logic       mem_req,
    input logic       mem_we,
    input logic       mem_ack,
    input logic [1:0] state,
    input logic       irq,
    input logic       err
);
    // R9
    start_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && mode != MODE_OFF) |=> (state == ST_WAIT));

    // R4
    err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> irq);

    // R4
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (state == ST_IDLE));

    // R6
    fetch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && mem_req) |-> !mem_we);

    // R10
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && mem_req && mem_we && mem_ack && mode == MODE_OFF)
        |=> (state == ST_IDLE && !irq && !err));

    // R11
    off_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && mode == MODE_OFF) |=> (state == ST_IDLE));
endmodule

bind dmac_chain_engine dmac_chain_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (mode),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .mem_ack (mem_ack),
    .state   (state),
    .irq     (irq),
    .err     (err)
);

// File: tb/dmac_chain_engine_tb.sv
module dmac_chain_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        dir = 1'b0;
    logic [31:0] ld_dev = '0, ld_mem = '0, ld_size = '0, ld_next = '0;
    logic        mem_req, mem_we, mem_ack, irq, err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_width, state;

    logic [31:0] bmem [0:63];
    int tests = 0, fails = 0, cycles = 0;
    int wr_cnt = 0, rd_cnt = 0, irq_cnt = 0, err_cnt = 0, fetch_cyc = 0;
    logic [31:0] last_addr = '0, last_data = '0;

    always #4 clk = ~clk;

    assign mem_ack   = mem_req;
    assign mem_rdata = bmem[mem_addr[7:2]];

    dmac_chain_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .dir(dir),
        .ld_dev(ld_dev), .ld_mem(ld_mem), .ld_size(ld_size), .ld_next(ld_next),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_width(mem_width), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .state(state), .irq(irq), .err(err)
    );

    // access log at the edge where each access completes
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (mem_we) begin
                wr_cnt    <= wr_cnt + 1;
                last_addr <= mem_addr;
                last_data <= mem_wdata;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    // pulse and state monitor away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) irq_cnt <= irq_cnt + 1;
            if (err) err_cnt <= err_cnt + 1;
            if (state == 2'd1) fetch_cyc <= fetch_cyc + 1;
        end
    end

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            fails = fails + 1;
            tests = tests + 1;
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic kick(input logic [1:0] m, input logic d, input logic [31:0] dv,
                        input logic [31:0] mm, input logic [31:0] sz, input logic [31:0] lk);
        @(negedge clk);
        mode = m; dir = d; ld_dev = dv; ld_mem = mm; ld_size = sz; ld_next = lk;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (state != 2'd0 && n < 8000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 8000, "R9 return to idle", 32'(n), 32'd8000);
        @(negedge clk);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]  m;
        logic        d;
        logic [31:0] sz;
        logic [31:0] lk;
        logic [11:0] nwr;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  nirq;
        logic        e;
    } vec_t;

    // mode 2 single-shot, 1 scatter-gather; dev 0x80, mem 0x40
    localparam vec_t VECS [11] = '{
        '{2'd2, 1'b1, 32'h0000_0003, 32'h1, 12'd3,    32'h80,   32'h3333_3333, 4'd1, 1'b0}, // R8 R5 m2d 4B
        '{2'd2, 1'b0, 32'h0000_2002, 32'h0, 12'd2,    32'h42,   32'hD00D_0001, 4'd0, 1'b0}, // R2 2B
        '{2'd2, 1'b0, 32'h0000_3003, 32'h1, 12'd3,    32'h42,   32'hD00D_0001, 4'd1, 1'b0}, // R2 1B
        '{2'd2, 1'b0, 32'h0000_1001, 32'h1, 12'd0,    32'h0,    32'h0,         4'd1, 1'b1}, // R4 bad width
        '{2'd2, 1'b0, 32'h0000_2400, 32'h0, 12'd0,    32'h0,    32'h0,         4'd1, 1'b1}, // R4 2B oversize
        '{2'd2, 1'b0, 32'h0000_0800, 32'h0, 12'd0,    32'h0,    32'h0,         4'd1, 1'b1}, // R4 4B oversize
        '{2'd2, 1'b0, 32'h0000_33FF, 32'h0, 12'd1023, 32'h43E,  32'hD00D_0001, 4'd0, 1'b0}, // R4 1B limit
        '{2'd2, 1'b0, 32'h0000_0000, 32'h1, 12'd0,    32'h0,    32'h0,         4'd1, 1'b0}, // R3 empty
        '{2'd2, 1'b1, 32'h0000_0001, 32'h3, 12'd1,    32'h80,   32'h1111_1111, 4'd1, 1'b0}, // R7 follow ignored
        '{2'd1, 1'b1, 32'h0000_0002, 32'h0, 12'd2,    32'h80,   32'h2222_2222, 4'd0, 1'b0}, // R5 end code in SG
        '{2'd2, 1'b0, 32'h0000_07FF, 32'h0, 12'd2047, 32'h2038, 32'hD00D_0001, 4'd0, 1'b0}  // R4 4B limit
    };

    initial begin
        for (int i = 0; i < 64; i++) bmem[i] = 32'hA5A5_0000 + 32'(i);
        bmem[16] = 32'h1111_1111; bmem[17] = 32'h2222_2222; bmem[18] = 32'h3333_3333;
        bmem[32] = 32'hD00D_0001; bmem[33] = 32'hD00D_0002;
        bmem[48] = 32'h84; bmem[49] = 32'h48; bmem[50] = 32'h2; bmem[51] = 32'h1;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(state == 2'd0, "R1 state in reset", 32'(state), 32'd0);
        chk(!mem_req && !irq && !err, "R1 outputs in reset", {29'd0, mem_req, irq, err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int v = 0; v < 11; v++) begin
            int w0, r0, i0, e0;
            w0 = wr_cnt; r0 = rd_cnt; i0 = irq_cnt; e0 = err_cnt;
            kick(VECS[v].m, VECS[v].d, 32'h80, 32'h40, VECS[v].sz, VECS[v].lk);
            wait_idle();
            chk(wr_cnt - w0 == int'(VECS[v].nwr), "R3 write count", 32'(wr_cnt - w0), 32'(VECS[v].nwr));
            chk(rd_cnt - r0 == int'(VECS[v].nwr), "R8 read count", 32'(rd_cnt - r0), 32'(VECS[v].nwr));
            chk(irq_cnt - i0 == int'(VECS[v].nirq), "R5 irq pulses", 32'(irq_cnt - i0), 32'(VECS[v].nirq));
            chk(err_cnt - e0 == int'(VECS[v].e), "R4 err pulses", 32'(err_cnt - e0), 32'(VECS[v].e));
            if (VECS[v].nwr != 0) begin
                chk(last_addr == VECS[v].addr, "R2 last write address", last_addr, VECS[v].addr);
                chk(last_data == VECS[v].data, "R8 last write data", last_data, VECS[v].data);
            end
        end

        // R9 state sequence after start
        kick(2'd2, 1'b0, 32'h80, 32'h40, 32'h4, 32'h0);
        chk(state == 2'd2, "R9 wait after start", 32'(state), 32'd2);
        @(negedge clk);
        chk(state == 2'd3, "R9 access after wait", 32'(state), 32'd3);
        wait_idle();

        // R6 scatter-gather chain through a fetched descriptor
        begin
            int w0, r0, i0, f0;
            w0 = wr_cnt; r0 = rd_cnt; i0 = irq_cnt; f0 = fetch_cyc;
            kick(2'd1, 1'b0, 32'h80, 32'h40, 32'h1, 32'hC3);
            wait_idle();
            chk(wr_cnt - w0 == 3, "R6 chain writes", 32'(wr_cnt - w0), 32'd3);
            chk(rd_cnt - r0 == 7, "R6 chain reads", 32'(rd_cnt - r0), 32'd7);
            chk(fetch_cyc - f0 == 4, "R6 fetch cycles", 32'(fetch_cyc - f0), 32'd4);
            chk(irq_cnt - i0 == 2, "R5 chain irqs", 32'(irq_cnt - i0), 32'd2);
            chk(last_addr == 32'h4C, "R6 fetched mem address", last_addr, 32'h4C);
            chk(last_data == 32'hD00D_0002, "R6 fetched dev address", last_data, 32'hD00D_0002);
        end

        // R10 disable while busy
        begin
            int w0, i0, e0;
            w0 = wr_cnt; i0 = irq_cnt; e0 = err_cnt;
            kick(2'd2, 1'b0, 32'h80, 32'h40, 32'h100, 32'h1);
            repeat (20) @(negedge clk);
            mode = 2'd0;
            wait_idle();
            chk((wr_cnt - w0 > 0) && (wr_cnt - w0 < 256), "R10 partial writes", 32'(wr_cnt - w0), 32'd11);
            chk(irq_cnt == i0 && err_cnt == e0, "R10 no pulses", 32'(irq_cnt - i0 + err_cnt - e0), 32'd0);
        end

        // R11 start ignored when disabled
        begin
            int r0;
            r0 = rd_cnt;
            kick(2'd0, 1'b0, 32'h80, 32'h40, 32'h4, 32'h1);
            repeat (3) @(negedge clk);
            chk(state == 2'd0, "R11 stays idle", 32'(state), 32'd0);
            chk(rd_cnt == r0, "R11 no access", 32'(rd_cnt - r0), 32'd0);
        end

        summary_and_end();
    end
endmodule